// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block turns a single pulse-width command into the two gate enables of a synchronous buck half-bridge. The command arrives as a decoded level code (low, high or mid-window). Before the opposite switch may turn on, the block waits for a comparator flag showing that the gate just released has actually discharged. The dead time therefore follows how fast each gate really falls, and not a fixed count. All four asynchronous inputs pass through two-flop synchronizers.

A mid-window command held for a programmable holdoff count puts both gates off and raises a shutdown status. The status clears as soon as the command leaves the window. A mid-window excursion shorter than the holdoff changes nothing. Each wait for a discharge flag is bounded by a watchdog. If the flag never comes, the block parks in a fault state with both gates off and a sticky fault bit. Only reset or dropping the enable clears that bit. Enable low forces both gates off.

Top module: `gate_seq`

## Requirements
- R1: After reset both gate outputs, `shutdown_o` and `fault_o` are 0. The first command level seen after reset or after enable rises is sequenced as a fresh transition through the matching wait.
- R2: When the synchronized command goes high (`pwm_code_i` = 2'b01), `lo_gate_o` drops on the third rising edge after the change. `hi_gate_o` rises only after `lo_gate_low_i` has been seen high while `lo_gate_o` was low.
- R3: When the synchronized command goes low (`pwm_code_i` = 2'b00), `hi_gate_o` drops on the third rising edge after the change. `lo_gate_o` rises only after `hi_gate_low_i` has been seen high while `hi_gate_o` was low.
- R4: `hi_gate_o` and `lo_gate_o` are never 1 in the same cycle.
- R5: A mid-window code (`pwm_code_i[1]` = 1) held for HOLDOFF_CYC consecutive synchronized cycles sets `shutdown_o` and drives both gates to 0.
- R6: A mid-window excursion shorter than HOLDOFF_CYC leaves the gate outputs where they were and keeps `shutdown_o` at 0.
- R7: Shutdown is released in the cycle the synchronized code leaves the mid window. Sequencing then resumes toward the new level.
- R8: While the synchronized enable is 0, both gates are 0 and `fault_o` is cleared, whatever the command.
- R9: If a wait for a discharge flag lasts WDOG_CYC non-mid cycles, `fault_o` goes to 1 with both gates 0. It stays there regardless of the command or the flags until enable falls or reset.
- R10: If the command reverses while a turn-on is pending, the pending gate is never asserted and the block sequences toward the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Asynchronous enable, 1 = run |
| pwm_code_i | input | 2 | Asynchronous level code: 00 low, 01 high, 1x mid window |
| lo_gate_low_i | input | 1 | Asynchronous flag: lower gate below its turn-off threshold |
| hi_gate_low_i | input | 1 | Asynchronous flag: upper gate-to-source below its threshold |
| hi_gate_o | output | 1 | Upper switch gate enable |
| lo_gate_o | output | 1 | Lower switch gate enable |
| shutdown_o | output | 1 | Mid-window shutdown active |
| fault_o | output | 1 | Sticky discharge-timeout fault |

## Verification
The bench holds the lower discharge flag back long enough for the command to reverse mid-wait. A design that kept the pending turn-on would pulse the upper gate. It sends a mid excursion just short of the holdoff, which a design with a wrong count or no reset on leaving the window would turn into a shutdown. It also pins a flag low until the watchdog fires. It then releases the flag and moves the command, so a fault that is not sticky, or that is cleared by anything other than enable, shows up as a gate turning back on. Exact-edge checks on the first gate drop catch a synchronizer with the wrong depth. A continuous monitor flags any overlap, or any turn-on that happens without the opposite discharge flag having been seen.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    // Decoded command level; any code with bit 1 set is the mid window
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_MID0 = 2'b10,
        LVL_MID1 = 2'b11
    } lvl_e;

    typedef enum logic [2:0] {
        ST_IDLE_OFF,
        ST_LOW_ON,
        ST_WAIT_LOW_OFF,
        ST_HIGH_ON,
        ST_WAIT_HIGH_OFF,
        ST_SHUTDOWN,
        ST_FAULT
    } seq_state_e;

    // Bundle of asynchronous inputs carried through one synchronizer
    typedef struct packed {
        logic [1:0] code;
        logic       en;
        logic       lo_low;
        logic       hi_low;
    } async_in_t;

    localparam int ASYNC_W = $bits(async_in_t);

    // Registered output word
    typedef struct packed {
        logic hi;
        logic lo;
        logic sd;
        logic flt;
    } gate_cmd_t;

    function automatic logic lvl_is_mid(input logic [1:0] c);
        return c[1];
    endfunction

    function automatic logic lvl_is_high(input logic [1:0] c);
        return c == LVL_HIGH;
    endfunction

    function automatic logic lvl_is_low(input logic [1:0] c);
        return c == LVL_LOW;
    endfunction

    function automatic gate_cmd_t cmd_of(input seq_state_e s);
        gate_cmd_t c;
        c.hi  = (s == ST_HIGH_ON);
        c.lo  = (s == ST_LOW_ON);
        c.sd  = (s == ST_SHUTDOWN);
        c.flt = (s == ST_FAULT);
        return c;
    endfunction

    function automatic logic st_is_wait(input seq_state_e s);
        return (s == ST_WAIT_LOW_OFF) || (s == ST_WAIT_HIGH_OFF);
    endfunction

endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gseq_span_timer.sv
// Counts consecutive cycles of 'run'; 'clr' restarts from zero.
// 'hit' is high while running with the count at its last value.
module gseq_span_timer #(
    parameter int LIMIT = 16,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          hit
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)                cnt <= '0;
        else if (run && (cnt != LAST)) cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == LAST);
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
    import gate_seq_pkg::*;
#(
    parameter int WCW   = 8,
    parameter int BLANK = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_s,
    input  logic [1:0]     code_s,
    input  logic           lo_low_s,
    input  logic           hi_low_s,
    input  logic           hold_hit,
    input  logic           wd_hit,
    input  logic [WCW-1:0] wd_cnt,
    output logic           state_chg,
    output logic           waiting,
    output gate_cmd_t      cmd
);
    seq_state_e st_q, st_d;
    logic       past_blank;
    logic       lo_ok, hi_ok;

    // flags older than the synchronizer depth belong to the current wait
    assign past_blank = (wd_cnt >= WCW'(BLANK));
    assign lo_ok      = lo_low_s && past_blank;
    assign hi_ok      = hi_low_s && past_blank;

    always_comb begin
        st_d = st_q;
        if (!en_s) begin
            st_d = ST_IDLE_OFF;
        end else if (st_q == ST_FAULT) begin
            st_d = ST_FAULT;
        end else if (hold_hit) begin
            st_d = ST_SHUTDOWN;
        end else begin
            unique case (st_q)
                ST_IDLE_OFF, ST_SHUTDOWN: begin
                    if (lvl_is_high(code_s))     st_d = ST_WAIT_LOW_OFF;
                    else if (lvl_is_low(code_s)) st_d = ST_WAIT_HIGH_OFF;
                end
                ST_LOW_ON: begin
                    if (lvl_is_high(code_s)) st_d = ST_WAIT_LOW_OFF;
                end
                ST_HIGH_ON: begin
                    if (lvl_is_low(code_s)) st_d = ST_WAIT_HIGH_OFF;
                end
                ST_WAIT_LOW_OFF: begin
                    if (lvl_is_low(code_s)) begin
                        st_d = ST_WAIT_HIGH_OFF;
                    end else if (lvl_is_high(code_s)) begin
                        if (lo_ok)       st_d = ST_HIGH_ON;
                        else if (wd_hit) st_d = ST_FAULT;
                    end
                end
                ST_WAIT_HIGH_OFF: begin
                    if (lvl_is_high(code_s)) begin
                        st_d = ST_WAIT_LOW_OFF;
                    end else if (lvl_is_low(code_s)) begin
                        if (hi_ok)       st_d = ST_LOW_ON;
                        else if (wd_hit) st_d = ST_FAULT;
                    end
                end
                default: st_d = ST_IDLE_OFF;
            endcase
        end
    end

    assign state_chg = (st_d != st_q);
    assign waiting   = st_is_wait(st_q) && !lvl_is_mid(code_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE_OFF;
            cmd  <= '0;
        end else begin
            st_q <= st_d;
            cmd  <= cmd_of(st_d);
        end
    end
endmodule

// File: rtl/gate_seq.sv
module gate_seq
    import gate_seq_pkg::*;
#(
    parameter int HOLDOFF_CYC = 42,
    parameter int WDOG_CYC    = 200,
    parameter int SYNC_N      = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic [1:0] pwm_code_i,
    input  logic       lo_gate_low_i,
    input  logic       hi_gate_low_i,
    output logic       hi_gate_o,
    output logic       lo_gate_o,
    output logic       shutdown_o,
    output logic       fault_o
);
    localparam int HCW = $clog2(HOLDOFF_CYC + 1);
    localparam int WCW = $clog2(WDOG_CYC + 1);

    async_in_t raw, syn;
    logic [1:0] code_s;
    logic       en_s, lo_low_s, hi_low_s, mid_s;
    logic [HCW-1:0] hold_cnt;
    logic [WCW-1:0] wd_cnt;
    logic       hold_hit, wd_hit, state_chg, waiting;
    gate_cmd_t  cmd;

    assign raw.code   = pwm_code_i;
    assign raw.en     = en_i;
    assign raw.lo_low = lo_gate_low_i;
    assign raw.hi_low = hi_gate_low_i;

    gseq_sync #(.W(ASYNC_W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    assign code_s   = syn.code;
    assign en_s     = syn.en;
    assign lo_low_s = syn.lo_low;
    assign hi_low_s = syn.hi_low;
    assign mid_s    = lvl_is_mid(code_s);

    gseq_span_timer #(.LIMIT(HOLDOFF_CYC)) u_hold (
        .clk (clk),
        .rst (rst),
        .clr (!mid_s),
        .run (mid_s),
        .cnt (hold_cnt),
        .hit (hold_hit)
    );

    gseq_span_timer #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk (clk),
        .rst (rst),
        .clr (state_chg),
        .run (waiting),
        .cnt (wd_cnt),
        .hit (wd_hit)
    );

    gseq_fsm #(.WCW(WCW), .BLANK(SYNC_N)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_s      (en_s),
        .code_s    (code_s),
        .lo_low_s  (lo_low_s),
        .hi_low_s  (hi_low_s),
        .hold_hit  (hold_hit),
        .wd_hit    (wd_hit),
        .wd_cnt    (wd_cnt),
        .state_chg (state_chg),
        .waiting   (waiting),
        .cmd       (cmd)
    );

    assign hi_gate_o  = cmd.hi;
    assign lo_gate_o  = cmd.lo;
    assign shutdown_o = cmd.sd;
    assign fault_o    = cmd.flt;

    logic unused_hold;
    assign unused_hold = ^hold_cnt;
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk (
    input logic clk,
    input logic rst,
    input logic en_s,
    input logic mid_s,
    input logic lo_low_s,
    input logic hi_low_s,
    input logic hi_gate_o,
    input logic lo_gate_o,
    input logic shutdown_o,
    input logic fault_o
);
    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(hi_gate_o && lo_gate_o));

    // R2
    hi_after_lo_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_gate_o) |-> $past(lo_low_s));

    // R3
    lo_after_hi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_gate_o) |-> $past(hi_low_s));

    // R5
    shutdown_needs_mid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown_o) |-> $past(mid_s));

    // R7
    shutdown_release_chk: assert property (@(posedge clk) disable iff (rst)
        (shutdown_o && en_s && !mid_s) |=> !shutdown_o);

    // R8
    disable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> (!hi_gate_o && !lo_gate_o && !fault_o));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_o && en_s) |=> (fault_o && !hi_gate_o && !lo_gate_o));
endmodule

bind gate_seq gate_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_s       (en_s),
    .mid_s      (mid_s),
    .lo_low_s   (lo_low_s),
    .hi_low_s   (hi_low_s),
    .hi_gate_o  (hi_gate_o),
    .lo_gate_o  (lo_gate_o),
    .shutdown_o (shutdown_o),
    .fault_o    (fault_o)
);

// File: tb/gate_seq_tb.sv
module gate_seq_tb;
    localparam int HOLD = 42;
    localparam int WD   = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_i = 1'b0;
    logic [1:0] pwm_code_i = 2'b00;
    logic lo_gate_low_i = 1'b0;
    logic hi_gate_low_i = 1'b0;
    logic hi_gate_o, lo_gate_o, shutdown_o, fault_o;

    always #5 clk = ~clk;

    gate_seq #(.HOLDOFF_CYC(HOLD), .WDOG_CYC(WD), .SYNC_N(2)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en_i),
        .pwm_code_i    (pwm_code_i),
        .lo_gate_low_i (lo_gate_low_i),
        .hi_gate_low_i (hi_gate_low_i),
        .hi_gate_o     (hi_gate_o),
        .lo_gate_o     (lo_gate_o),
        .shutdown_o    (shutdown_o),
        .fault_o       (fault_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // gate discharge model
    int  lo_dly = 3, hi_dly = 3;
    bit  lo_stuck = 0, hi_stuck = 0;
    int  lo_off_cnt = 0, hi_off_cnt = 0;
    always @(negedge clk) begin
        lo_off_cnt    <= lo_gate_o ? 0 : lo_off_cnt + 1;
        hi_off_cnt    <= hi_gate_o ? 0 : hi_off_cnt + 1;
        lo_gate_low_i <= !lo_stuck && !lo_gate_o && (lo_off_cnt >= lo_dly);
        hi_gate_low_i <= !hi_stuck && !hi_gate_o && (hi_off_cnt >= hi_dly);
    end

    // scoreboard
    typedef struct {
        int    due;
        logic  hi, lo, sd, flt;
        string tag;
    } exp_t;
    exp_t sb[$];

    task automatic expect_now(input logic hi, input logic lo, input logic sd,
                              input logic flt, input string tag);
        exp_t e;
        e.due = cyc; e.hi = hi; e.lo = lo; e.sd = sd; e.flt = flt; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard pops plus continuous overlap and turn-on guard
    bit lo_seen = 0, hi_seen = 0;
    logic hi_prev = 0, lo_prev = 0;
    int hi_rises = 0;
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if ({hi_gate_o, lo_gate_o, shutdown_o, fault_o} !== {e.hi, e.lo, e.sd, e.flt}) begin
                n_fail++;
                $display("FAIL %s: got hi=%0b lo=%0b sd=%0b flt=%0b expected hi=%0b lo=%0b sd=%0b flt=%0b",
                         e.tag, hi_gate_o, lo_gate_o, shutdown_o, fault_o, e.hi, e.lo, e.sd, e.flt);
            end
        end
        if (!rst) begin
            // R4
            n_chk++;
            if (hi_gate_o && lo_gate_o) begin
                n_fail++;
                $display("FAIL R4: got hi=1 lo=1 expected not both");
            end
            // R2
            if (hi_gate_o && !hi_prev) begin
                hi_rises++;
                n_chk++;
                if (!lo_seen) begin
                    n_fail++;
                    $display("FAIL R2: got upper on with lo flag unseen=0 expected 1");
                end
            end
            // R3
            if (lo_gate_o && !lo_prev) begin
                n_chk++;
                if (!hi_seen) begin
                    n_fail++;
                    $display("FAIL R3: got lower on with hi flag unseen=0 expected 1");
                end
            end
        end
        lo_seen = lo_gate_o ? 1'b0 : (lo_seen | lo_gate_low_i);
        hi_seen = hi_gate_o ? 1'b0 : (hi_seen | hi_gate_low_i);
        hi_prev = hi_gate_o;
        lo_prev = lo_gate_o;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int rises_before;
        step(3);
        expect_now(0, 0, 0, 0, "R1 reset");
        @(negedge clk) rst = 0;
        step(5);
        expect_now(0, 0, 0, 0, "R8 enable low after reset");

        // R1 fresh start on low level
        en_i = 1; pwm_code_i = 2'b00;
        step(20);
        expect_now(0, 1, 0, 0, "R1 first level low");

        // R2 rising command, exact drop edge then upper on
        pwm_code_i = 2'b01;
        step(2);
        expect_now(0, 1, 0, 0, "R2 lower still on before 3rd edge");
        step(1);
        expect_now(0, 0, 0, 0, "R2 lower off at 3rd edge");
        step(20);
        expect_now(1, 0, 0, 0, "R2 upper on");

        // R3 falling command
        pwm_code_i = 2'b00;
        step(2);
        expect_now(1, 0, 0, 0, "R3 upper still on before 3rd edge");
        step(1);
        expect_now(0, 0, 0, 0, "R3 upper off at 3rd edge");
        step(20);
        expect_now(0, 1, 0, 0, "R3 lower on");

        // R6 short mid excursion while upper on
        pwm_code_i = 2'b01;
        step(25);
        pwm_code_i = 2'b10;
        step(10);
        expect_now(1, 0, 0, 0, "R6 mid excursion holds state");
        step(HOLD - 14);
        pwm_code_i = 2'b01;
        step(10);
        expect_now(1, 0, 0, 0, "R6 no shutdown after short mid");

        // R5 long mid
        pwm_code_i = 2'b11;
        step(HOLD + 15);
        expect_now(0, 0, 1, 0, "R5 shutdown after holdoff");

        // R7 release to low
        pwm_code_i = 2'b00;
        step(3);
        expect_now(0, 0, 0, 0, "R7 shutdown released");
        step(20);
        expect_now(0, 1, 0, 0, "R7 resumes to lower on");

        // R10 reversal while upper turn-on pending
        lo_dly = 30;
        rises_before = hi_rises;
        pwm_code_i = 2'b01;
        step(8);
        pwm_code_i = 2'b00;
        step(25);
        expect_now(0, 1, 0, 0, "R10 reversal returns to lower");
        step(1);
        n_chk++;
        if (hi_rises != rises_before) begin
            n_fail++;
            $display("FAIL R10: got %0d upper turn-ons expected %0d", hi_rises, rises_before);
        end
        lo_dly = 3;

        // R9 watchdog fault
        lo_stuck = 1;
        pwm_code_i = 2'b01;
        step(WD + 30);
        expect_now(0, 0, 0, 1, "R9 fault on missing flag");
        lo_stuck = 0;
        step(20);
        expect_now(0, 0, 0, 1, "R9 fault sticky after flag returns");
        pwm_code_i = 2'b00;
        step(20);
        expect_now(0, 0, 0, 1, "R9 fault sticky across command");
        en_i = 0;
        step(5);
        expect_now(0, 0, 0, 0, "R8 enable low clears fault");
        en_i = 1;
        step(20);
        expect_now(0, 1, 0, 0, "R1 fresh start after enable");

        // R8 enable low while upper on
        pwm_code_i = 2'b01;
        step(20);
        expect_now(1, 0, 0, 0, "R2 upper on before disable");
        en_i = 0;
        step(5);
        expect_now(0, 0, 0, 0, "R8 enable low forces off");
        en_i = 1;
        step(20);
        expect_now(1, 0, 0, 0, "R1 upper on after re-enable");

        step(3);
        finish_run();
    end
endmodule